// File: doc/BRIEF.md
# Control Endpoint Phase Handshake Controller

This block keeps the phase state of a USB device's default control endpoint and picks the handshake that answers each decoded token. A token decoder delivers SETUP, IN and OUT events. The controller replies with a one-cycle registered strobe that carries one of four answers: NAK, ACK, STALL or a zero-length data packet. Software drives the transfer through one control word. The word holds a stall bit, a set-only bit that arms the data phase and a set-only bit that arms the status phase. It also holds a strobe that empties the receive buffer and a read-only copy of the buffer-full flag.

The endpoint NAKs every IN and OUT token until software arms the status phase. Once the status phase is armed, an IN gets a zero-length packet and an OUT gets an ACK. A completed status phase, a new SETUP token or either reset drops the endpoint back to NAKing. Stall overrides every answer except the one to SETUP, which is always accepted.

Top module: `ep0_phase_ctrl`

## Requirements
- R1: The control word reads back with stall at bit 0, status-armed at bit 1, data-armed at bit 2 and the `buf_full_i` input at bit 5. Every other bit, bit 4 included, reads 0, and writing ones to those bits changes nothing.
- R2: While stall and status-armed are both 0, IN (kind 01) and OUT (kind 10) tokens get NAK (code 00), whatever the value of data-armed.
- R3: While status-armed is 1 and stall is 0, an IN token gets a zero-length packet (code 11) and an OUT token gets ACK (code 01).
- R4: Status-armed clears on `status_done_i`, on a SETUP token, on bus reset and on master reset. Any of these clears wins over a write of 1 in the same cycle.
- R5: Writing 1 to bit 2 sets data-armed, and writing 1 to bit 1 sets status-armed. Writing 0 to either bit leaves it unchanged. A SETUP token clears data-armed, and this clear wins over a write in the same cycle.
- R6: The stall bit takes the value of bit 0 on every write. While it is 1, IN and OUT tokens get STALL (code 10), even with status-armed set.
- R7: A SETUP token (kind 00) always gets ACK, even while stalled, and leaves the stall bit unchanged.
- R8: Master reset (`rst_ni` low, asynchronous) and bus reset (`bus_rst_i`, synchronous) clear all three control bits. During a bus-reset cycle, tokens get no handshake and writes are ignored.
- R9: `hs_vld_o` is high for exactly the cycle after the edge that samples a valid token. The answer is decided on the state held before any write or clear in that same cycle. Token kind 11 and idle cycles produce no strobe.
- R10: `buf_clr_o` pulses for one cycle after a write with bit 4 set, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| bus_rst_i | input | 1 | Bus reset, synchronous, active high |
| tok_vld_i | input | 1 | Decoded token present this cycle |
| tok_kind_i | input | 2 | Token kind: 00 SETUP, 01 IN, 10 OUT, 11 unused |
| status_done_i | input | 1 | Status phase finished pulse |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| buf_full_i | input | 1 | Buffer-full flag from the buffer logic |
| reg_rdata_o | output | 32 | Control word readback |
| buf_clr_o | output | 1 | Receive buffer clear pulse |
| hs_vld_o | output | 1 | Handshake strobe |
| hs_code_o | output | 2 | Handshake: 00 NAK, 01 ACK, 10 STALL, 11 zero-length packet |

## Verification
The handshake strobe and its code, and the buffer-clear pulse, are due one clock after the edge that samples the token or write. Readback follows the updated state in that same cycle, combinationally, so it also shows the new value one edge later. The bench drives inputs on the falling edge and updates its behavioural model right after the rising edge. It compares every output at the following falling edge, one cycle after each stimulus. Master reset is checked a short delay after it is asserted, with no clock edge in between.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  parameter int unsigned REG_W = 32;

  localparam int unsigned BIT_STALL = 0;
  localparam int unsigned BIT_STS   = 1;
  localparam int unsigned BIT_DAT   = 2;
  localparam int unsigned BIT_CLR   = 4;
  localparam int unsigned BIT_FULL  = 5;

  localparam logic [1:0] TOK_SETUP = 2'b00;
  localparam logic [1:0] TOK_IN    = 2'b01;
  localparam logic [1:0] TOK_OUT   = 2'b10;
  localparam logic [1:0] TOK_NONE  = 2'b11;

  localparam logic [1:0] HS_NAK   = 2'b00;
  localparam logic [1:0] HS_ACK   = 2'b01;
  localparam logic [1:0] HS_STALL = 2'b10;
  localparam logic [1:0] HS_ZLP   = 2'b11;

  typedef struct packed {
    logic stall;
    logic sts;
    logic dat;
  } ctl_state_t;
endpackage

// File: rtl/ep0_ctl_regs.sv
module ep0_ctl_regs
  import ep0_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_rst_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         setup_i,
  input  logic         status_done_i,
  output ctl_state_t   st_o,
  output logic         buf_clr_o
);
  ctl_state_t st_q, st_d;
  logic       clr_q;

  always_comb begin
    st_d = st_q;
    if (wr_i) begin
      st_d.stall = wdata_i[BIT_STALL];
      if (wdata_i[BIT_STS]) st_d.sts = 1'b1;
      if (wdata_i[BIT_DAT]) st_d.dat = 1'b1;
    end
    // clears override sets
    if (status_done_i) st_d.sts = 1'b0;
    if (setup_i) begin
      st_d.sts = 1'b0;
      st_d.dat = 1'b0;
    end
    if (bus_rst_i) st_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      clr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      clr_q <= wr_i && wdata_i[BIT_CLR] && !bus_rst_i;
    end
  end

  assign st_o      = st_q;
  assign buf_clr_o = clr_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[W-1:BIT_FULL], wdata_i[3]};

  assert_bus_rst_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (st_q == '0));
  assert_setup_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i |=> (!st_q.sts && !st_q.dat));
  assert_done_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_done_i |=> !st_q.sts);
  assert_setup_keeps_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_i && !wr_i && !bus_rst_i) |=> $stable(st_q.stall));
  assert_clr_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i || bus_rst_i) |=> !buf_clr_o);
endmodule

// File: rtl/ep0_hs_decode.sv
module ep0_hs_decode
  import ep0_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_rst_i,
  input  logic       tok_vld_i,
  input  logic [1:0] tok_kind_i,
  input  ctl_state_t st_i,
  output logic       hs_vld_o,
  output logic [1:0] hs_code_o
);
  logic       take;
  logic [1:0] code_d;
  logic       vld_q;
  logic [1:0] code_q;

  assign take = tok_vld_i && !bus_rst_i && (tok_kind_i != TOK_NONE);

  always_comb begin
    if (tok_kind_i == TOK_SETUP)  code_d = HS_ACK;
    else if (st_i.stall)          code_d = HS_STALL;
    else if (!st_i.sts)           code_d = HS_NAK;
    else if (tok_kind_i == TOK_IN) code_d = HS_ZLP;
    else                          code_d = HS_ACK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      code_q <= HS_NAK;
    end else begin
      vld_q <= take;
      if (take) code_q <= code_d;
    end
  end

  assign hs_vld_o  = vld_q;
  assign hs_code_o = code_q;

  assert_no_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> !hs_vld_o);
  assert_setup_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && tok_kind_i == TOK_SETUP) |=> (hs_vld_o && hs_code_o == HS_ACK));
  assert_stall_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && tok_kind_i != TOK_SETUP && st_i.stall) |=> (hs_code_o == HS_STALL));
  assert_nak_unarmed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && tok_kind_i != TOK_SETUP && !st_i.stall && !st_i.sts) |=> (hs_code_o == HS_NAK));
  assert_status_in_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && tok_kind_i == TOK_IN && !st_i.stall && st_i.sts) |=> (hs_code_o == HS_ZLP));
endmodule

// File: rtl/ep0_rd_mux.sv
module ep0_rd_mux
  import ep0_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  ctl_state_t   st_i,
  input  logic         buf_full_i,
  output logic [W-1:0] rdata_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == BIT_STALL)     begin : g_s assign rdata_o[b] = st_i.stall; end
    else if (b == BIT_STS)  begin : g_t assign rdata_o[b] = st_i.sts;   end
    else if (b == BIT_DAT)  begin : g_d assign rdata_o[b] = st_i.dat;   end
    else if (b == BIT_FULL) begin : g_f assign rdata_o[b] = buf_full_i; end
    else                    begin : g_z assign rdata_o[b] = 1'b0;       end
  end
endmodule

// File: rtl/ep0_phase_ctrl.sv
module ep0_phase_ctrl
  import ep0_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_rst_i,
  input  logic         tok_vld_i,
  input  logic [1:0]   tok_kind_i,
  input  logic         status_done_i,
  input  logic         reg_wr_i,
  input  logic [W-1:0] reg_wdata_i,
  input  logic         buf_full_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         buf_clr_o,
  output logic         hs_vld_o,
  output logic [1:0]   hs_code_o
);
  ctl_state_t st;
  logic       setup_seen;

  assign setup_seen = tok_vld_i && (tok_kind_i == TOK_SETUP);

  ep0_ctl_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .bus_rst_i,
    .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .setup_i(setup_seen), .status_done_i,
    .st_o(st), .buf_clr_o
  );

  ep0_hs_decode u_hs (
    .clk_i, .rst_ni, .bus_rst_i,
    .tok_vld_i, .tok_kind_i, .st_i(st),
    .hs_vld_o, .hs_code_o
  );

  ep0_rd_mux #(.W(W)) u_rd (
    .st_i(st), .buf_full_i, .rdata_o(reg_rdata_o)
  );

  assert_reserved_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[W-1:BIT_FULL+1] == '0) && (reg_rdata_o[4:3] == 2'b00));
endmodule

// File: tb/ep0_phase_ctrl_bench.sv
`timescale 1ns/1ps
module ep0_phase_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst = 1'b0;
  logic        tv = 1'b0;
  logic [1:0]  tk = 2'b11;
  logic        sd = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wd = '0;
  logic        bf = 1'b0;
  logic [31:0] rd;
  logic        clr, hv;
  logic [1:0]  hc;

  int total = 0, bad = 0;
  bit m_stall, m_sts, m_dat, m_hv, m_clr;
  logic [1:0] m_hc = 2'b00;

  always #2 clk = ~clk;

  ep0_phase_ctrl u_ep0_phase_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst), .tok_vld_i(tv),
    .tok_kind_i(tk), .status_done_i(sd), .reg_wr_i(wr), .reg_wdata_i(wd),
    .buf_full_i(bf), .reg_rdata_o(rd), .buf_clr_o(clr), .hs_vld_o(hv),
    .hs_code_o(hc)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    return {26'd0, bf, 2'b00, m_dat, m_sts, m_stall};
  endfunction

  task automatic compare(string req);
    chk("R1", "readback", rd, exp_rd());
    chk("R9", "hs_vld", {31'd0, hv}, {31'd0, m_hv});
    if (m_hv) chk(req, "hs_code", {30'd0, hc}, {30'd0, m_hc});
    chk("R10", "buf_clr", {31'd0, clr}, {31'd0, m_clr});
  endtask

  // one cycle: drive at negedge, model after posedge, compare at next negedge
  task automatic step(bit w, logic [31:0] d, bit v, logic [1:0] k, bit done, bit br);
    string req;
    wr = w; wd = d; tv = v; tk = k; sd = done; bus_rst = br;
    if (k == 2'b00) req = "R7";
    else if (m_stall) req = "R6";
    else if (m_sts) req = "R3";
    else req = "R2";
    @(posedge clk);
    m_hv = !br && v && (k != 2'b11);
    if (m_hv) begin
      if (k == 2'b00) m_hc = 2'b01;
      else if (m_stall) m_hc = 2'b10;
      else if (!m_sts) m_hc = 2'b00;
      else if (k == 2'b01) m_hc = 2'b11;
      else m_hc = 2'b01;
    end
    m_clr = !br && w && d[4];
    if (br) begin
      m_stall = 0; m_sts = 0; m_dat = 0;
    end else begin
      if (w) begin
        m_stall = d[0];
        if (d[1]) m_sts = 1;
        if (d[2]) m_dat = 1;
      end
      if (done) m_sts = 0;
      if (v && k == 2'b00) begin m_sts = 0; m_dat = 0; end
    end
    @(negedge clk);
    wr = 0; tv = 0; sd = 0; bus_rst = 0;
    compare(req);
  endtask

  task automatic idle(); step(0, 0, 0, 2'b11, 0, 0); endtask
  task automatic tok(logic [1:0] k); step(0, 0, 1, k, 0, 0); endtask
  task automatic wreg(logic [31:0] d); step(1, d, 0, 2'b11, 0, 0); endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "reset readback", rd, 32'd0);
    chk("R8", "reset hs_vld", {31'd0, hv}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    tok(2'b00);                 // R7 SETUP -> ACK
    tok(2'b01); tok(2'b10);     // R2 NAK unarmed
    wreg(32'h4);                // R5 data armed
    chk("R5", "data armed", rd, 32'h4);
    tok(2'b01);                 // R2 still NAK
    wreg(32'h0);                // R5 zero write keeps data
    chk("R5", "zero write keeps", rd, 32'h4);
    wreg(32'h2);                // R3 arm status
    tok(2'b01); tok(2'b10);     // R3 ZLP, ACK
    step(0, 0, 0, 2'b11, 1, 0); // R4 status done
    chk("R4", "status done clears", rd[1], 1'b0);
    step(1, 32'h6, 1, 2'b00, 0, 0); // R4/R5 SETUP beats write
    chk("R4", "setup beats write", rd, 32'h0);
    step(1, 32'h2, 0, 2'b11, 1, 0); // R4 done beats write
    chk("R4", "done beats write", rd, 32'h0);
    wreg(32'h3);                // R6 stall + status
    tok(2'b01); tok(2'b10);     // R6 STALL
    tok(2'b00);                 // R7 ACK while stalled
    chk("R7", "stall kept on setup", rd[0], 1'b1);
    wreg(32'h0); tok(2'b10);    // R6 stall released -> R2 NAK
    bf = 1'b1;
    wreg(32'hFFFF_FFFF);        // R1 reserved ignored, R10 clear
    chk("R1", "reserved ignored", rd, 32'h27);
    bf = 1'b0; idle();
    tok(2'b11);                 // R9 kind 11 no strobe
    step(1, 32'h16, 1, 2'b01, 0, 1); // R8 bus reset
    chk("R8", "bus reset", rd, 32'h0);
    wreg(32'h7);
    rst_n = 1'b0; #1;           // R8 async master reset
    chk("R8", "master reset", rd, 32'h0);
    m_stall = 0; m_sts = 0; m_dat = 0; m_hv = 0; m_clr = 0;
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      bf = r[9];
      step(r[0] & r[1], {26'd0, r[10], r[11], r[12], r[13], r[14], r[15]},
           r[2], r[4:3], r[5] & r[6], (r[8:7] == 2'b11) && r[16]);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule